// File: doc/BRIEF.md
# Storage Controller Enable and Shutdown Handshake

This block is the controller-side part of the control and status exchange that a host uses to bring a storage controller up, take it down and shut it down cleanly. The host writes a configuration register that holds an enable bit and a two-bit shutdown request. The block reports progress through a status register that holds a ready flag and a two-bit shutdown progress field. An internal engine supplies a single "engine ok" level. Every transition of the ready flag, and the finish of a normal shutdown, waits for that level.

The ready flag follows the enable bit after a programmable number of clock cycles. A normal shutdown request moves the shutdown progress field from normal to busy and then to complete. An abrupt request moves it to complete at once. When the engine holds a pending change back for longer than its budget, a one-cycle timeout pulse is raised. The shutdown budget is five times the enable/disable budget. Reads are combinational from the address. Writes take effect on the clock edge that samples the write strobe.

Top module: `shc_ctrl_handshake`

## Requirements
- R1: After reset, both registers read zero (enable 0, shutdown request none, ready 0, shutdown progress normal) and the timeout output is low.
- R2: Offset 0x14 reads enable at bit 0 and the shutdown request at bits 15:14 (0 none, 1 normal, 2 abrupt, 3 stored but not acted on), with all other bits zero. Offset 0x1C reads ready at bit 0 and the shutdown progress at bits 3:2 (0 normal, 1 busy, 2 complete), with all other bits zero. Any other offset reads zero.
- R3: A write to any offset other than 0x14, including the status offset, changes no register state.
- R4: When enable is written to 1 while the shutdown request is 0 and engine ok is high, ready rises RDY_DLY clock edges after the write edge.
- R5: When enable is written to 0 while ready is 1, ready falls RDY_DLY clock edges after the write edge, whatever the value of engine ok.
- R6: Ready does not rise while the shutdown request is nonzero, even with enable set.
- R7: A normal shutdown request (1) written while the progress field is normal sets it to busy on the next edge. The field holds busy for SHDN_DLY cycles and becomes complete on the following edge when engine ok is high. The ready flag is unaffected.
- R8: An abrupt shutdown request (2) moves the progress field from normal, or from busy, to complete on the next edge, with no busy cycle.
- R9: While the progress field is complete, writing the shutdown request back to 0 returns the field to normal on the next edge.
- R10: If a ready change is still pending after TMO_CYC cycles, the timeout output is high for exactly one cycle, namely the TMO_CYC-th pending cycle.
- R11: If the progress field stays busy for 5*TMO_CYC cycles, the timeout output is high for exactly one cycle, namely the 5*TMO_CYC-th busy cycle.
- R12: While engine ok is low, a ready rise and a busy-to-complete step are held back. Once the delay has elapsed, they complete on the first edge at which engine ok is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| eng_ok | input | 1 | Engine readiness level |
| ready_o | output | 1 | Copy of the ready flag |
| sst_o | output | 2 | Copy of the shutdown progress field |
| tmo_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench measures the exact edge at which ready rises and falls. A delay counter that is off by one moves that edge and is reported. It checks that an abrupt request never shows a busy cycle. A sequencer that routes it through busy would show progress 1 one cycle after the write. It stalls the engine to place each timeout pulse on its cycle: a budget counted wrongly, or a shutdown window not scaled by five, pulses early, late or twice. It also writes to the status offset and to unmapped offsets, which a loose address decode would let through to the configuration register.

// File: rtl/shc_pkg.sv
// Package: shared encodings and register layout for the enable/shutdown
// handshake block. Assumes a byte-offset register space.
package shc_pkg;

    // Shutdown request codes held in the configuration register.
    typedef enum logic [1:0] {
        SHN_NONE   = 2'd0,
        SHN_NORMAL = 2'd1,
        SHN_ABRUPT = 2'd2,
        SHN_RSVD   = 2'd3
    } shn_e;

    // Shutdown progress codes reported in the status register.
    typedef enum logic [1:0] {
        SST_NORMAL = 2'd0,
        SST_BUSY   = 2'd1,
        SST_DONE   = 2'd2,
        SST_RSVD   = 2'd3
    } sst_e;

    localparam int CFG_OFS     = 'h14;
    localparam int STS_OFS     = 'h1C;
    localparam int EN_BIT      = 0;
    localparam int SHN_LO      = 14;
    localparam int SHN_HI      = 15;
    localparam int RDY_BIT     = 0;
    localparam int SST_LO      = 2;
    localparam int SST_HI      = 3;

endpackage

// File: rtl/shc_cfg_regs.sv
// Configuration register: captures the enable bit and the shutdown request
// on a write to the configuration offset. Assumes DATA_W >= 16.
module shc_cfg_regs
    import shc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output shn_e              shn
);

    logic hit;
    logic unused_wbits;

    assign hit          = wr && (addr == ADDR_W'(CFG_OFS));
    assign unused_wbits = ^{wdata[DATA_W-1:SHN_HI+1], wdata[SHN_LO-1:EN_BIT+1]};

    // Capture the host's enable and shutdown request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            shn <= SHN_NONE;
        end else if (hit) begin
            en  <= wdata[EN_BIT];
            shn <= shn_e'(wdata[SHN_HI:SHN_LO]);
        end
    end

endmodule

// File: rtl/shc_ready_seq.sv
// Ready sequencer: moves the ready flag towards the enable bit after DLY
// cycles. A rise also needs no shutdown request and engine ok high. A fall
// needs only the delay. Assumes DLY >= 1.
module shc_ready_seq
    import shc_pkg::*;
#(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  shn_e shn,
    input  logic eng_ok,
    output logic rdy,
    output logic pend
);

    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt;
    logic          up_req;
    logic          dn_req;
    logic          dly_met;

    assign up_req  = !rdy && en && (shn == SHN_NONE);
    assign dn_req  = rdy && !en;
    assign pend    = up_req || dn_req;
    assign dly_met = (cnt == CW'(DLY - 1));

    // Count pending cycles and toggle ready once the delay is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
            cnt <= '0;
        end else if (!pend) begin
            cnt <= '0;
        end else if (dly_met && (dn_req || eng_ok)) begin
            rdy <= !rdy;
            cnt <= '0;
        end else if (!dly_met) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/shc_shdn_seq.sv
// Shutdown sequencer: steps the progress field normal -> busy -> done for a
// normal request, or straight to done for an abrupt one. A cleared request
// returns it to normal. Assumes DLY >= 1.
module shc_shdn_seq
    import shc_pkg::*;
#(
    parameter int DLY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  shn_e shn,
    input  logic eng_ok,
    output sst_e sst,
    output logic pend
);

    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt;
    logic          dly_met;

    assign pend    = (sst == SST_BUSY);
    assign dly_met = (cnt == CW'(DLY - 1));

    // Advance the shutdown progress field and its busy-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sst <= SST_NORMAL;
            cnt <= '0;
        end else begin
            case (sst)
                SST_NORMAL: begin
                    cnt <= '0;
                    if (shn == SHN_NORMAL)      sst <= SST_BUSY;
                    else if (shn == SHN_ABRUPT) sst <= SST_DONE;
                end
                SST_BUSY: begin
                    if (shn == SHN_ABRUPT)        sst <= SST_DONE;
                    else if (dly_met && eng_ok)   sst <= SST_DONE;
                    else if (!dly_met)            cnt <= cnt + 1'b1;
                end
                SST_DONE: begin
                    cnt <= '0;
                    if (shn == SHN_NONE) sst <= SST_NORMAL;
                end
                default: begin
                    sst <= SST_NORMAL;
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/shc_wait_timer.sv
// Wait timer: counts consecutive pending cycles. It pulses expire for one
// cycle in the BUDGET-th pending cycle and stays quiet until pending drops.
// Assumes BUDGET >= 1.
module shc_wait_timer #(
    parameter int BUDGET = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic expire
);

    localparam int CW = $clog2(BUDGET + 1);

    logic [CW-1:0] cnt;

    assign expire = pend && (cnt == CW'(BUDGET - 1));

    // Saturating count of the cycles the request has been outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n || !pend) begin
            cnt <= '0;
        end else if (cnt != CW'(BUDGET)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/shc_ctrl_handshake.sv
// Top: register decode and status for the enable/shutdown handshake.
// Reads are combinational from bus_addr. Writes land on the clock edge.
// The timeout output merges the two wait timers, the second with a budget
// of SHDN_TMO_MULT times the first.
module shc_ctrl_handshake
    import shc_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32,
    parameter int RDY_DLY       = 4,
    parameter int SHDN_DLY      = 6,
    parameter int TMO_CYC       = 16,
    parameter int SHDN_TMO_MULT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_ok,
    output logic              ready_o,
    output logic [1:0]        sst_o,
    output logic              tmo_o
);

    localparam int NTMR = 2;

    logic            cfg_en;
    shn_e            cfg_shn;
    logic            rdy;
    logic            rdy_pend;
    sst_e            sst;
    logic            sst_pend;
    logic [NTMR-1:0] pend_v;
    logic [NTMR-1:0] exp_v;

    shc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en    (cfg_en),
        .shn   (cfg_shn)
    );

    shc_ready_seq #(.DLY(RDY_DLY)) i_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_en),
        .shn    (cfg_shn),
        .eng_ok (eng_ok),
        .rdy    (rdy),
        .pend   (rdy_pend)
    );

    shc_shdn_seq #(.DLY(SHDN_DLY)) i_shdn (
        .clk    (clk),
        .rst_n  (rst_n),
        .shn    (cfg_shn),
        .eng_ok (eng_ok),
        .sst    (sst),
        .pend   (sst_pend)
    );

    assign pend_v = {sst_pend, rdy_pend};

    // One timer per handshake, budget chosen by index.
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam int BUD = (g == 0) ? TMO_CYC : SHDN_TMO_MULT * TMO_CYC;
        shc_wait_timer #(.BUDGET(BUD)) i_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend   (pend_v[g]),
            .expire (exp_v[g])
        );
    end

    assign tmo_o   = |exp_v;
    assign ready_o = rdy;
    assign sst_o   = sst;

    // Read mux: place fields at their bit positions for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CFG_OFS)) begin
            bus_rdata[EN_BIT]        = cfg_en;
            bus_rdata[SHN_HI:SHN_LO] = cfg_shn;
        end else if (bus_addr == ADDR_W'(STS_OFS)) begin
            bus_rdata[RDY_BIT]       = rdy;
            bus_rdata[SST_HI:SST_LO] = sst;
        end
    end

endmodule

// File: rtl/shc_handshake_chk.sv
// Checker: temporal properties of the handshake, bound into the top module.
module shc_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [1:0] shn,
    input logic       eng_ok,
    input logic       rdy,
    input logic [1:0] sst,
    input logic       tmo
);

    p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(en) && $past(shn) == 2'd0 && $past(eng_ok)));

    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> !$past(en));

    p_no_rise_in_shdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shn) != 2'd0) |-> !$rose(rdy));

    p_busy_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sst == 2'd1 && $past(sst) != 2'd1) |-> ($past(sst) == 2'd0 && $past(shn) == 2'd1));

    p_done_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sst == 2'd2 && $past(sst) == 2'd1) |-> ($past(eng_ok) || $past(shn) == 2'd2));

    p_sst_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sst != 2'd3);

    p_tmo_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> (sst == 2'd1 || (!rdy && en && shn == 2'd0) || (rdy && !en)));

endmodule

bind shc_ctrl_handshake shc_handshake_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .shn    (cfg_shn),
    .eng_ok (eng_ok),
    .rdy    (rdy),
    .sst    (sst),
    .tmo    (tmo_o)
);

// File: tb/test_shc_ctrl_handshake.sv
module test_shc_ctrl_handshake;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int RD = 4;
    localparam int SD = 6;
    localparam int TO = 16;
    localparam int MU = 5;
    localparam logic [AW-1:0] A_CFG = 12'h014;
    localparam logic [AW-1:0] A_STS = 12'h01C;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] exp_cfg;
        logic          ign;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{12'h014, 32'hFFFF_FFFF, 32'h0000_C001, 1'b0},
        '{12'h014, 32'hFFFF_3FFE, 32'h0000_0000, 1'b0},
        '{12'h014, 32'h0000_4000, 32'h0000_4000, 1'b0},
        '{12'h01C, 32'hFFFF_FFFF, 32'h0000_4000, 1'b1},
        '{12'h020, 32'h0000_0001, 32'h0000_4000, 1'b1},
        '{12'h014, 32'h0000_8001, 32'h0000_8001, 1'b0},
        '{12'h010, 32'h0000_0000, 32'h0000_8001, 1'b1},
        '{12'h014, 32'h0000_0000, 32'h0000_0000, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          eng_ok = 1'b1;
    logic          ready_o;
    logic [1:0]    sst_o;
    logic          tmo_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    shc_ctrl_handshake #(
        .ADDR_W(AW), .DATA_W(DW), .RDY_DLY(RD), .SHDN_DLY(SD),
        .TMO_CYC(TO), .SHDN_TMO_MULT(MU)
    ) i_shc_ctrl_handshake (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_ok(eng_ok),
        .ready_o(ready_o), .sst_o(sst_o), .tmo_o(tmo_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_reset();
        eng_ok = 1'b1;
        rst_n  = 1'b0;
        step(3);
        rst_n  = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        do_reset();

        // R1: reset state
        rd(A_CFG, v); chk("R1 cfg", v, 32'h0);
        rd(A_STS, v); chk("R1 sts", v, 32'h0);
        chk("R1 tmo", {31'h0, tmo_o}, 32'h0);

        // R2 / R3: vector table of writes and configuration readback
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].d);
            rd(A_CFG, v);
            if (VEC[i].ign) chk("R3 ignored write", v, VEC[i].exp_cfg);
            else            chk("R2 cfg fields", v, VEC[i].exp_cfg);
            rd(A_STS, v);
            chk("R2 sts spare bits", v & 32'hFFFF_FFF2, 32'h0);
        end
        rd(12'h020, v); chk("R2 unmapped read", v, 32'h0);

        // R4: ready rises RD edges after enable
        do_reset();
        wr(A_CFG, 32'h1);
        step(RD - 1); rd(A_STS, v); chk("R4 ready early", v, 32'h0);
        step(1);      rd(A_STS, v); chk("R4 ready set", v, 32'h1);

        // R3: status write while ready does not change state
        wr(A_STS, 32'h0);
        rd(A_STS, v); chk("R3 status write", v, 32'h1);

        // R5: ready falls RD edges after disable, engine stalled
        eng_ok = 1'b0;
        wr(A_CFG, 32'h0);
        step(RD - 1); chk("R5 ready held", {31'h0, ready_o}, 32'h1);
        step(1);      chk("R5 ready clear", {31'h0, ready_o}, 32'h0);

        // R10 / R12: enable with engine stalled, timeout pulse placement
        wr(A_CFG, 32'h1);
        step(TO - 2); chk("R10 no early tmo", {31'h0, tmo_o}, 32'h0);
        step(1);      chk("R10 tmo pulse", {31'h0, tmo_o}, 32'h1);
        step(1);      chk("R10 tmo single", {31'h0, tmo_o}, 32'h0);
        chk("R12 ready held", {31'h0, ready_o}, 32'h0);
        eng_ok = 1'b1;
        step(1);      chk("R12 ready on engine ok", {31'h0, ready_o}, 32'h1);

        // R7: normal shutdown timing, ready unaffected
        wr(A_CFG, 32'h4001);
        chk("R7 not yet busy", {30'h0, sst_o}, 32'h0);
        step(1);      chk("R7 busy", {30'h0, sst_o}, 32'h1);
        step(SD - 1); chk("R7 still busy", {30'h0, sst_o}, 32'h1);
        step(1);      rd(A_STS, v); chk("R7 done with ready", v, 32'h9);

        // R9: clear request returns to normal
        wr(A_CFG, 32'h1);
        step(1);      chk("R9 back to normal", {30'h0, sst_o}, 32'h0);

        // R8: abrupt request skips busy
        wr(A_CFG, 32'h8001);
        chk("R8 before edge", {30'h0, sst_o}, 32'h0);
        step(1);      chk("R8 straight to done", {30'h0, sst_o}, 32'h2);
        wr(A_CFG, 32'h1);
        step(1);      chk("R9 abrupt cleared", {30'h0, sst_o}, 32'h0);

        // R6: enable with shutdown request pending keeps ready low
        do_reset();
        wr(A_CFG, 32'h4001);
        step(2 * RD); chk("R6 no ready", {31'h0, ready_o}, 32'h0);

        // R11 / R12: shutdown timeout at MU*TO busy cycles
        do_reset();
        eng_ok = 1'b0;
        wr(A_CFG, 32'h4000);
        step(MU * TO - 1); chk("R11 no early tmo", {31'h0, tmo_o}, 32'h0);
        step(1);           chk("R11 tmo pulse", {31'h0, tmo_o}, 32'h1);
        step(1);           chk("R11 tmo single", {31'h0, tmo_o}, 32'h0);
        chk("R12 busy held", {30'h0, sst_o}, 32'h1);
        eng_ok = 1'b1;
        step(1);           chk("R12 done on engine ok", {30'h0, sst_o}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule